// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This unit sits between a processor's address generation and the memory system. It turns each virtual address into a physical address by adding a base value. Before that address is accepted, the unit checks that the virtual address lies below a limit. The unit holds two base/limit pairs. Instruction fetches use the code pair, and every other access uses the data pair. The access-type input picks the pair, so software never names it.

The limit applies to the virtual address, not the physical one. The compare therefore runs alongside the addition, not after it. A request that reaches or passes its limit does not produce a physical address. Instead it raises a one-cycle fault and reports the offending virtual address. In supervisor mode the effective base is zero and no limit is checked, so the operating system sees its own addresses untranslated.

Privileged software loads the four registers through a simple write port. Results come out registered, one cycle after the request.

Top module: `reloc_unit`

## Requirements
- R1: After reset, `pa_valid` and `fault` are low. Both bases are 0 and both limits hold the all-ones value.
- R2: For a user-mode request without a fault, `pa_addr` equals the virtual address plus the selected base, taken modulo 2^PA_W. `pa_valid` is high for exactly the one cycle after the request cycle.
- R3: A request with `req_fetch`=1 uses the code pair. A request with `req_fetch`=0 uses the data pair.
- R4: If a user-mode virtual address is greater than or equal to the selected limit, `fault` is high for the one cycle after the request. In that cycle `pa_valid` stays low and `fault_vaddr` holds the request's virtual address.
- R5: A user-mode virtual address strictly below the selected limit never faults.
- R6: A request with `req_super`=1 yields `pa_addr` equal to the virtual address with `pa_valid` high. It never faults, whatever the base and limit values are.
- R7: A register write takes effect for requests from the cycle after the write strobe. A request in the same cycle as the write still sees the old value.
- R8: In a cycle that follows a cycle with no request, `pa_valid` and `fault` are both low.
- R9: `cfg_sel` picks the register to write: 0 is the code base, 1 the code limit, 2 the data base and 3 the data limit.
- R10: With the reset limits, a user access to virtual address all-ones faults. A user access to all-ones minus one does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_fetch | input | 1 | 1 = instruction fetch (code pair), 0 = data access |
| req_super | input | 1 | 1 = supervisor mode, relocation bypassed |
| req_vaddr | input | VA_W | Virtual address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (see R9) |
| cfg_wdata | input | max(VA_W,PA_W) | Write data |
| pa_valid | output | 1 | Physical address valid, one-cycle pulse |
| pa_addr | output | PA_W | Physical address |
| fault | output | 1 | Limit violation, one-cycle pulse |
| fault_vaddr | output | VA_W | Virtual address that caused the fault |

## Verification
Each request's result is due exactly one clock after the request cycle. In that cycle either `pa_valid` or `fault` is high, never both. A register write changes behaviour only for requests issued from the cycle after the strobe. The bench tags every expected result with the cycle count at which it is due. The monitor compares only in that cycle and expects both outputs low in every other cycle. Same-cycle write-plus-request cases are predicted from the register model as it stood before the write.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  // register select for the write port; bit 1 picks the pair, bit 0 the field
  typedef enum logic [1:0] {
    SEL_CODE_BASE  = 2'd0,
    SEL_CODE_LIMIT = 2'd1,
    SEL_DATA_BASE  = 2'd2,
    SEL_DATA_LIMIT = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_PAIRS = 2;
  localparam int unsigned PAIR_CODE = 0;
  localparam int unsigned PAIR_DATA = 1;
endpackage

// File: rtl/reloc_pair_regs.sv
module reloc_pair_regs #(
  parameter int unsigned VA_W  = 24,
  parameter int unsigned PA_W  = 24,
  parameter int unsigned CFG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_base,
  input  logic             we_limit,
  input  logic [CFG_W-1:0] wdata,
  output logic [PA_W-1:0]  base_q,
  output logic [VA_W-1:0]  limit_q
);
  logic [PA_W-1:0] base_d;
  logic [VA_W-1:0] limit_d;

  always_comb begin
    base_d  = base_q;
    limit_d = limit_q;
    if (we_base)  base_d  = wdata[PA_W-1:0];
    if (we_limit) limit_d = wdata[VA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '1;
    end else begin
      if (we_base)  base_q  <= base_d;
      if (we_limit) limit_q <= limit_d;
    end
  end
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
  parameter int unsigned VA_W = 24,
  parameter int unsigned PA_W = 24
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [PA_W-1:0] base,
  input  logic [VA_W-1:0] limit,
  input  logic            super_mode,
  output logic [PA_W-1:0] paddr,
  output logic            over_limit
);
  logic [PA_W-1:0] va_ext;
  logic [PA_W-1:0] eff_base;

  generate
    if (PA_W > VA_W) begin : g_widen
      assign va_ext = {{(PA_W-VA_W){1'b0}}, vaddr};
    end else if (PA_W == VA_W) begin : g_same
      assign va_ext = vaddr;
    end else begin : g_narrow
      assign va_ext = vaddr[PA_W-1:0];
    end
  endgenerate

  // adder and comparator share only the virtual address: they run side by side
  always_comb begin
    eff_base   = super_mode ? '0 : base;
    paddr      = va_ext + eff_base;
    over_limit = !super_mode && (vaddr >= limit);
  end
endmodule

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int unsigned VA_W = 24,
  parameter int unsigned PA_W = 24,
  localparam int unsigned CFG_W = (VA_W > PA_W) ? VA_W : PA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_fetch,
  input  logic             req_super,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             pa_valid,
  output logic [PA_W-1:0]  pa_addr,
  output logic             fault,
  output logic [VA_W-1:0]  fault_vaddr
);
  import reloc_pkg::*;

  logic [PA_W-1:0] base_q  [NUM_PAIRS];
  logic [VA_W-1:0] limit_q [NUM_PAIRS];

  generate
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
      logic pair_hit;
      assign pair_hit = cfg_we && (cfg_sel[1] == 1'(g));
      reloc_pair_regs #(.VA_W(VA_W), .PA_W(PA_W), .CFG_W(CFG_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_base  (pair_hit && !cfg_sel[0]),
        .we_limit (pair_hit &&  cfg_sel[0]),
        .wdata    (cfg_wdata),
        .base_q   (base_q[g]),
        .limit_q  (limit_q[g])
      );
    end
  endgenerate

  logic [PA_W-1:0] sel_base;
  logic [VA_W-1:0] sel_limit;
  logic [PA_W-1:0] xl_paddr;
  logic            xl_over;

  always_comb begin
    sel_base  = req_fetch ? base_q[PAIR_CODE]  : base_q[PAIR_DATA];
    sel_limit = req_fetch ? limit_q[PAIR_CODE] : limit_q[PAIR_DATA];
  end

  reloc_xlate #(.VA_W(VA_W), .PA_W(PA_W)) xlate_i (
    .vaddr      (req_vaddr),
    .base       (sel_base),
    .limit      (sel_limit),
    .super_mode (req_super),
    .paddr      (xl_paddr),
    .over_limit (xl_over)
  );

  logic valid_d, fault_d;

  always_comb begin
    valid_d = req_valid && !xl_over;
    fault_d = req_valid &&  xl_over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_valid    <= 1'b0;
      fault       <= 1'b0;
      pa_addr     <= '0;
      fault_vaddr <= '0;
    end else begin
      pa_valid <= valid_d;
      fault    <= fault_d;
      if (valid_d) pa_addr     <= xl_paddr;
      if (fault_d) fault_vaddr <= req_vaddr;
    end
  end
endmodule

// File: rtl/reloc_unit_chk.sv
module reloc_unit_chk #(
  parameter int unsigned VA_W = 24,
  parameter int unsigned PA_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_super,
  input logic [VA_W-1:0] req_vaddr,
  input logic            pa_valid,
  input logic [PA_W-1:0] pa_addr,
  input logic            fault,
  input logic [VA_W-1:0] fault_vaddr
);
  a_r4_valid_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pa_valid && fault));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!pa_valid && !fault));

  a_r2_one_cycle_result: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (pa_valid || fault));

  a_r6_super_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_super) |=> (pa_valid && (pa_addr == PA_W'($past(req_vaddr)))));

  a_r4_fault_reports_vaddr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_super) |=> (!fault || (fault_vaddr == $past(req_vaddr))));
endmodule

bind reloc_unit reloc_unit_chk #(.VA_W(VA_W), .PA_W(PA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_super   (req_super),
  .req_vaddr   (req_vaddr),
  .pa_valid    (pa_valid),
  .pa_addr     (pa_addr),
  .fault       (fault),
  .fault_vaddr (fault_vaddr)
);

// File: tb/reloc_unit_tb_top.sv
`timescale 1ns/1ps
module reloc_unit_tb_top;
  localparam int VA_W = 24;
  localparam int PA_W = 24;
  localparam logic [23:0] ALL1 = 24'hFFFFFF;

  logic clk, rst_n;
  logic req_valid, req_fetch, req_super;
  logic [VA_W-1:0] req_vaddr;
  logic cfg_we;
  logic [1:0] cfg_sel;
  logic [23:0] cfg_wdata;
  logic pa_valid, fault;
  logic [PA_W-1:0] pa_addr;
  logic [VA_W-1:0] fault_vaddr;

  reloc_unit #(.VA_W(VA_W), .PA_W(PA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
    .req_super(req_super), .req_vaddr(req_vaddr), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .pa_valid(pa_valid),
    .pa_addr(pa_addr), .fault(fault), .fault_vaddr(fault_vaddr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench register model: index 0 code, 1 data
  logic [23:0] m_base [2];
  logic [23:0] m_lim  [2];

  // scoreboard queues
  bit          q_v   [$];
  bit          q_f   [$];
  logic [23:0] q_a   [$];
  int          q_due [$];
  string       q_tag [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // one cycle of stimulus; expected result computed from the model before any write
  task automatic step(input bit do_req, input bit fetch, input bit sup,
                      input logic [23:0] va, input bit do_wr,
                      input logic [1:0] sel, input logic [23:0] wd,
                      input string tag);
    int p;
    @(posedge clk); #1;
    req_valid = do_req; req_fetch = fetch; req_super = sup; req_vaddr = va;
    cfg_we = do_wr; cfg_sel = sel; cfg_wdata = wd;
    if (do_req) begin
      p = fetch ? 0 : 1;
      q_due.push_back(cyc + 1);
      q_tag.push_back(tag);
      if (sup) begin
        q_v.push_back(1); q_f.push_back(0); q_a.push_back(va);
      end else if (va >= m_lim[p]) begin
        q_v.push_back(0); q_f.push_back(1); q_a.push_back(va);
      end else begin
        q_v.push_back(1); q_f.push_back(0); q_a.push_back(va + m_base[p]);
      end
    end
    if (do_wr) begin
      if (sel[0]) m_lim[sel[1]] = wd; else m_base[sel[1]] = wd;
    end
  endtask

  task automatic rq(input bit fetch, input bit sup, input logic [23:0] va, input string tag);
    step(1, fetch, sup, va, 0, 2'd0, 24'h0, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [23:0] wd);
    step(0, 0, 0, 24'h0, 1, sel, wd, "R9");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 24'h0, 0, 2'd0, 24'h0, "R8");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_due.size() != 0 && q_due[0] == cyc) begin
        bit ev, ef; logic [23:0] ea; string t;
        ev = q_v.pop_front(); ef = q_f.pop_front(); ea = q_a.pop_front();
        t = q_tag.pop_front(); void'(q_due.pop_front());
        chk(pa_valid == ev, t, "pa_valid", 32'(pa_valid), 32'(ev));
        chk(fault == ef, t, "fault", 32'(fault), 32'(ef));
        if (ev) chk(pa_addr == ea, t, "pa_addr", 32'(pa_addr), 32'(ea));
        if (ef) chk(fault_vaddr == ea, t, "fault_vaddr", 32'(fault_vaddr), 32'(ea));
      end else begin
        chk(!pa_valid && !fault, "R8", "idle outputs", {30'b0, pa_valid, fault}, 32'h0);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_base[0] = '0; m_base[1] = '0; m_lim[0] = ALL1; m_lim[1] = ALL1;
    rst_n = 0; req_valid = 0; req_fetch = 0; req_super = 0; req_vaddr = '0;
    cfg_we = 0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!pa_valid && !fault, "R1", "reset outputs", {30'b0, pa_valid, fault}, 32'h0);
    rst_n = 1;
    idle(2);
    // R1 / R10: reset registers, all-ones limit
    rq(0, 0, ALL1, "R10");
    rq(0, 0, ALL1 - 1, "R10");
    rq(1, 0, ALL1, "R10");
    rq(1, 0, 24'h000123, "R1");
    idle(1);
    // R9: load the four registers by select code
    wr(2'd0, 24'h100000);
    wr(2'd2, 24'h200000);
    wr(2'd1, 24'h010000);
    wr(2'd3, 24'h020000);
    // R3 / R2: pair selection and addition
    rq(1, 0, 24'h002345, "R3");
    rq(0, 0, 24'h002345, "R3");
    // R4 / R5 limit edges
    rq(1, 0, 24'h010000, "R4");
    rq(1, 0, 24'h00FFFF, "R5");
    rq(0, 0, 24'h018000, "R5");
    rq(1, 0, 24'h018000, "R4");
    rq(0, 0, 24'h020000, "R4");
    rq(0, 0, 24'h01FFFF, "R5");
    // R6 supervisor bypass, beyond limit
    rq(1, 1, 24'h500000, "R6");
    rq(0, 1, ALL1, "R6");
    idle(2);
    // R2 wrap-around
    wr(2'd3, ALL1);
    wr(2'd2, 24'hFFF000);
    rq(0, 0, 24'h002000, "R2");
    // R7 same-cycle write uses old value, next cycle new value
    step(1, 0, 0, 24'h000100, 1, 2'd2, 24'h000010, "R7");
    rq(0, 0, 24'h000100, "R7");
    step(1, 1'b1, 0, 24'h000500, 1, 2'd1, 24'h000400, "R7");
    rq(1, 0, 24'h000500, "R7");
    idle(3);
    done = 1;
    if (q_due.size() != 0) chk(0, "R2", "pending results", 32'(q_due.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule